// File: doc/BRIEF.md
# Path Overhead Byte Inserter

This block sits on the transmit byte stream of an STS-1 or TUG-3 payload and fills in the nine path overhead byte slots. A frame-timing source upstream marks each byte slot with a valid strobe. It also marks which slots belong to the overhead column, gives each one an overhead index, and pulses a frame-start strobe on the first byte of each frame. Payload slots pass through with one cycle of latency. Each overhead slot is filled from one of two places: a nine-byte register image that a processor writes through a simple write port, or the latest eight-byte group received on a serial overhead port.

The serial port is driven by the block. It produces a bit clock and a framing pulse, and it samples one input data line. The trace byte can come from the receive side or from an alarm port, in place of its normal source. The parity byte is always calculated: it is a BIP-8 over every byte sent in the previous frame, and a test mask can flip chosen bits of it. When write-back is on, each overhead byte that is sent is stored in the register image, where the processor can read it back.

Overhead indices are J1=0, B3=1, C2=2, G1=3, F2=4, H4=5, Z3=6, Z4=7, Z5=8.

Top module: `poh_inserter`

## Requirements
- R1: After reset, tx_valid and tx_data are 0, every register image byte reads as 0, and ser_frm is 1.
- R2: tx_valid equals byte_en one cycle later. When byte_en is high and poh_en is low, tx_data one cycle later equals pay_in.
- R3: An overhead slot with index 0 or 2..8 whose source bit is 0 sends the register image byte at that index. Register address equals overhead index, rd_data returns the image byte at rd_addr, and rd_data is 0 for rd_addr above 8.
- R4: An overhead slot whose source bit is 1 sends a byte from the last complete serial group. The serial port timing works as follows:
  - One bit period is DIV clocks. ser_clk is low for the first DIV/2 clocks of each period.
  - ser_data is sampled in the last clock of each period.
  - A cycle is 65 periods. ser_frm is high for exactly the first period of each cycle.
  - The next 64 bits arrive MSB first, in the order J1, C2, G1, F2, H4, Z3, Z4, Z5.
  - ser_frm changes only when ser_clk falls.
- R5: src_sel, g1_sel and b3_mask are captured on the frame_start byte. That byte and the rest of its frame use the captured values. Changes made later in the frame have no effect until the next frame_start.
- R6: g1_sel picks the G1 source:
  - 1 sends rx_g1.
  - 2 sends alm_g1.
  - 0 and 3 use src_sel bit 3 like the other bytes.
- R7: The B3 slot (index 1) sends the XOR of all bytes sent with byte_en from one frame_start byte up to the byte before the next one. Bytes sent before the first frame_start count as a frame. src_sel bit 1 has no effect.
- R8: The sent B3 byte is the parity XORed with the captured b3_mask.
- R9: While wb_en is high, each sent overhead byte with index 0..8, including B3, is stored into the register image at its index. A processor write to the same address in the same cycle wins.
- R10: A slot with poh_en high and poh_idx above 8 passes pay_in through as payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_en | input | 1 | Byte slot present this cycle |
| frame_start | input | 1 | First byte of a frame (with byte_en) |
| poh_en | input | 1 | Slot belongs to the overhead column |
| poh_idx | input | 4 | Overhead byte index |
| pay_in | input | 8 | Incoming payload byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| src_sel | input | 9 | Per-index source: 0 register, 1 serial |
| g1_sel | input | 2 | G1 source override |
| b3_mask | input | 8 | Parity error mask |
| wb_en | input | 1 | Write sent overhead back into image |
| rx_g1 | input | 8 | G1 value from receive side |
| alm_g1 | input | 8 | G1 value from alarm port |
| wr_en | input | 1 | Register image write strobe |
| wr_addr | input | 4 | Register image write address |
| wr_data | input | 8 | Register image write data |
| rd_addr | input | 4 | Register image read address |
| rd_data | output | 8 | Register image read data |
| ser_clk | output | 1 | Serial overhead bit clock |
| ser_frm | output | 1 | Serial overhead framing pulse |
| ser_data | input | 1 | Serial overhead data |

## Verification
The bench changes src_sel and b3_mask in the middle of a frame. A design that applied them at once, instead of at frame_start, would send the wrong source or mask for the rest of that frame. It checks that B3 counts the frame_start byte in the new frame and every overhead byte, B3 included, in the old one. Getting either boundary wrong shows up as a wrong parity byte in the next frame.

The serial image is checked byte by byte after a full cycle of known bits. A shift in bit or byte order would scramble the mapping from serial bytes to indices. The bench also makes a processor write and a write-back hit the same address in the same cycle; if write-back took priority, the written value would be lost.

// File: rtl/poh_inserter.sv
module poh_inserter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_en,
  input  logic       frame_start,
  input  logic       poh_en,
  input  logic [3:0] poh_idx,
  input  logic [7:0] pay_in,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic [8:0] src_sel,
  input  logic [1:0] g1_sel,
  input  logic [7:0] b3_mask,
  input  logic       wb_en,
  input  logic [7:0] rx_g1,
  input  logic [7:0] alm_g1,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       ser_clk,
  output logic       ser_frm,
  input  logic       ser_data
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int NB = 9;
  localparam logic [6:0] LAST_BIT = 7'd64;

  logic [DW-1:0] div_cnt;
  logic [6:0]    bit_cnt;
  logic [63:0]   sreg, ser_img;
  logic          tick;

  assign tick    = div_cnt == DW'(DIV - 1);
  assign ser_clk = div_cnt >= DW'(DIV / 2);
  assign ser_frm = bit_cnt == 7'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      sreg    <= '0;
      ser_img <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        bit_cnt <= (bit_cnt == LAST_BIT) ? 7'd0 : bit_cnt + 7'd1;
        if (bit_cnt != 7'd0) sreg <= {sreg[62:0], ser_data};
        if (bit_cnt == LAST_BIT) ser_img <= {sreg[62:0], ser_data};
      end
    end
  end

  logic       fs;
  logic [8:0] src_q, src_e;
  logic [1:0] g1_q, g1_e;
  logic [7:0] mask_q, mask_e;
  logic [7:0] bip_acc, bip_prev;
  logic [7:0] img [NB];

  assign fs     = byte_en & frame_start;
  assign src_e  = fs ? src_sel : src_q;
  assign g1_e   = fs ? g1_sel  : g1_q;
  assign mask_e = fs ? b3_mask : mask_q;

  logic       in_col;
  logic [3:0] idx_c;
  logic [2:0] sn;
  logic [5:0] sb_lo;
  logic [7:0] ser_b, ins, out_b;

  assign in_col = poh_en && (poh_idx < 4'(NB));
  assign idx_c  = (poh_idx < 4'(NB)) ? poh_idx : 4'd0;
  assign sn     = (idx_c == 4'd0) ? 3'd0 : 3'(idx_c - 4'd1);
  assign sb_lo  = {3'd7 - sn, 3'b000};
  assign ser_b  = ser_img[sb_lo +: 8];

  always_comb begin
    ins = src_e[idx_c] ? ser_b : img[idx_c];
    if (idx_c == 4'd3 && g1_e == 2'd1) ins = rx_g1;
    if (idx_c == 4'd3 && g1_e == 2'd2) ins = alm_g1;
    if (idx_c == 4'd1) ins = (fs ? bip_acc : bip_prev) ^ mask_e;
  end

  assign out_b   = in_col ? ins : pay_in;
  assign rd_data = (rd_addr < 4'(NB)) ? img[rd_addr] : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
      src_q    <= '0;
      g1_q     <= '0;
      mask_q   <= '0;
      bip_acc  <= '0;
      bip_prev <= '0;
    end else begin
      tx_valid <= byte_en;
      if (byte_en) begin
        tx_data <= out_b;
        bip_acc <= fs ? out_b : bip_acc ^ out_b;
      end
      if (fs) begin
        bip_prev <= bip_acc;
        src_q    <= src_sel;
        g1_q     <= g1_sel;
        mask_q   <= b3_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) img[i] <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (wr_en && wr_addr == 4'(i))
          img[i] <= wr_data;
        else if (wb_en && byte_en && in_col && idx_c == 4'(i))
          img[i] <= out_b;
      end
    end
  end
endmodule

// File: rtl/poh_inserter_chk.sv
module poh_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_en,
  input logic       frame_start,
  input logic       poh_en,
  input logic [3:0] poh_idx,
  input logic [7:0] pay_in,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic [1:0] g1_sel,
  input logic [7:0] rx_g1,
  input logic       ser_clk,
  input logic       ser_frm
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en |=> tx_valid);
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_en |=> !tx_valid);
  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && !poh_en) |=> tx_data == $past(pay_in));
  // R10
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && poh_en && poh_idx > 4'd8) |=> tx_data == $past(pay_in));
  // R6
  g1_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && frame_start && poh_en && poh_idx == 4'd3 && g1_sel == 2'd1)
      |=> tx_data == $past(rx_g1));
  // R4
  frm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_frm) |-> $fell(ser_clk));
  // R4
  frm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_frm) |-> $fell(ser_clk));
endmodule

bind poh_inserter poh_inserter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .frame_start(frame_start),
  .poh_en(poh_en), .poh_idx(poh_idx), .pay_in(pay_in), .tx_data(tx_data),
  .tx_valid(tx_valid), .g1_sel(g1_sel), .rx_g1(rx_g1),
  .ser_clk(ser_clk), .ser_frm(ser_frm)
);

// File: tb/poh_inserter_bench.sv
module poh_inserter_bench;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0;
  logic byte_en = 0, frame_start = 0, poh_en = 0;
  logic [3:0] poh_idx = 0;
  logic [7:0] pay_in = 0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic [8:0] src_sel = 0;
  logic [1:0] g1_sel = 0;
  logic [7:0] b3_mask = 0;
  logic wb_en = 0;
  logic [7:0] rx_g1 = 8'hC7, alm_g1 = 8'h5E;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic ser_clk, ser_frm;
  logic ser_data = 0;

  poh_inserter #(.DIV(DIV)) u_poh_inserter (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .frame_start(frame_start),
    .poh_en(poh_en), .poh_idx(poh_idx), .pay_in(pay_in), .tx_data(tx_data),
    .tx_valid(tx_valid), .src_sel(src_sel), .g1_sel(g1_sel), .b3_mask(b3_mask),
    .wb_en(wb_en), .rx_g1(rx_g1), .alm_g1(alm_g1), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ser_clk(ser_clk), .ser_frm(ser_frm), .ser_data(ser_data)
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] macc = 0, mprev = 0;
  logic [7:0] img_m [9];
  logic [63:0] ser_word = 0;

  int slot = 0;
  logic prev_sclk = 0;
  always @(negedge clk) begin
    if (!rst_n) slot = 0;
    else if (prev_sclk && !ser_clk) begin
      if (ser_frm) slot = 0;
      else begin
        slot = slot + 1;
        if (slot <= 64) ser_data = ser_word[64 - slot];
      end
    end
    prev_sclk = ser_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit fs, input bit poh, input logic [3:0] idx,
                      input logic [7:0] pay, input logic [7:0] exp, input string req);
    byte_en = 1; frame_start = fs; poh_en = poh; poh_idx = idx; pay_in = pay;
    @(negedge clk);
    chk(tx_valid === 1'b1 && tx_data === exp, req, int'(tx_data), int'(exp));
    if (fs) begin mprev = macc; macc = exp; end
    else macc = macc ^ exp;
    if (wb_en && poh && idx < 9) img_m[idx] = exp;
    byte_en = 0; frame_start = 0; poh_en = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a < 9) img_m[a] = d;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    rd_addr = a; #1;
    chk(rd_data === exp, req, int'(rd_data), int'(exp));
  endtask

  function automatic logic [7:0] ser_byte(input int i);
    int n = (i == 0) ? 0 : i - 1;
    return ser_word[63 - 8*n -: 8];
  endfunction

  task automatic run_frame(input logic [8:0] sv, input logic [1:0] gv, input logic [7:0] mv,
                           input logic [8:0] sa, input logic [1:0] ga, input logic [7:0] ma,
                           input logic [7:0] seed);
    logic [7:0] e;
    string req;
    src_sel = sv; g1_sel = gv; b3_mask = mv;
    xfer(1, 0, 0, seed, seed, "R2");
    src_sel = sa; g1_sel = ga; b3_mask = ma;
    for (int i = 0; i < 9; i++) begin
      if (i == 1) begin e = mprev ^ mv; req = (mv != 0) ? "R8" : "R7"; end
      else if (i == 3 && gv == 2'd1) begin e = rx_g1; req = "R6"; end
      else if (i == 3 && gv == 2'd2) begin e = alm_g1; req = "R6"; end
      else if (sv[i]) begin e = ser_byte(i); req = "R4"; end
      else begin e = img_m[i]; req = "R3"; end
      if (sa != sv || ga != gv || ma != mv) req = {req, "/R5"};
      xfer(1'b0, 1'b1, 4'(i), 8'hEE, e, req);
    end
    for (int k = 0; k < 4; k++)
      xfer(1'b0, 1'b0, 4'd0, seed + 8'(k * 37), seed + 8'(k * 37), "R2");
  endtask

  task automatic t_reset;
    chk(tx_valid === 1'b0, "R1", int'(tx_valid), 0);
    chk(tx_data === 8'd0, "R1", int'(tx_data), 0);
    chk(ser_frm === 1'b1, "R1", int'(ser_frm), 1);
    for (int a = 0; a < 9; a++) rd_chk(4'(a), 8'd0, "R1");
  endtask

  task automatic t_pass;
    xfer(0, 0, 4'd0, 8'h12, 8'h12, "R2");
    xfer(0, 0, 4'd5, 8'hF0, 8'hF0, "R2");
    xfer(0, 1, 4'd9, 8'h3A, 8'h3A, "R10");
    xfer(0, 1, 4'd15, 8'h81, 8'h81, "R10");
    @(negedge clk);
    chk(tx_valid === 1'b0, "R2", int'(tx_valid), 0);
  endtask

  task automatic t_register;
    for (int a = 0; a < 9; a++) wr(4'(a), 8'h10 + 8'(a * 17));
    for (int a = 0; a < 9; a++) rd_chk(4'(a), img_m[a], "R3");
    rd_chk(4'd12, 8'd0, "R3");
    run_frame(9'h000, 2'd0, 8'h00, 9'h000, 2'd0, 8'h00, 8'h41);
    run_frame(9'h000, 2'd0, 8'h00, 9'h000, 2'd0, 8'h00, 8'h9C);
  endtask

  task automatic t_serial_timing;
    int hi, per;
    while (ser_frm !== 1'b0) @(negedge clk);
    while (ser_frm !== 1'b1) @(negedge clk);
    hi = 0;
    while (ser_frm === 1'b1) begin hi++; @(negedge clk); end
    per = hi;
    while (ser_frm !== 1'b1) begin per++; @(negedge clk); end
    chk(hi == DIV, "R4", hi, DIV);
    chk(per == 65 * DIV, "R4", per, 65 * DIV);
  endtask

  task automatic t_serial;
    ser_word = 64'hA1B2_C3D4_E5F6_0718;
    repeat (2 * 65 * DIV + 10) @(negedge clk);
    run_frame(9'h1FF, 2'd0, 8'h00, 9'h1FF, 2'd0, 8'h00, 8'h27);
    run_frame(9'h0A5, 2'd0, 8'h00, 9'h0A5, 2'd0, 8'h00, 8'h63);
  endtask

  task automatic t_latch;
    run_frame(9'h000, 2'd0, 8'h00, 9'h1FF, 2'd2, 8'hFF, 8'h55);
    run_frame(9'h1FF, 2'd0, 8'h00, 9'h000, 2'd0, 8'h00, 8'h66);
  endtask

  task automatic t_g1;
    run_frame(9'h000, 2'd1, 8'h00, 9'h000, 2'd1, 8'h00, 8'h70);
    run_frame(9'h000, 2'd2, 8'h00, 9'h000, 2'd2, 8'h00, 8'h71);
    run_frame(9'h008, 2'd3, 8'h00, 9'h008, 2'd3, 8'h00, 8'h72);
  endtask

  task automatic t_mask;
    run_frame(9'h000, 2'd0, 8'hFF, 9'h000, 2'd0, 8'hFF, 8'h13);
    run_frame(9'h000, 2'd0, 8'h81, 9'h000, 2'd0, 8'h00, 8'h14);
    run_frame(9'h000, 2'd0, 8'h00, 9'h000, 2'd0, 8'h00, 8'h15);
  endtask

  task automatic t_writeback;
    wb_en = 1;
    run_frame(9'h1FF, 2'd0, 8'h24, 9'h1FF, 2'd0, 8'h24, 8'h88);
    for (int a = 0; a < 9; a++) rd_chk(4'(a), img_m[a], "R9");
    wr_en = 1; wr_addr = 4'd2; wr_data = 8'h3C;
    xfer(0, 1, 4'd2, 8'h00, ser_byte(2), "R9");
    wr_en = 0; img_m[2] = 8'h3C;
    rd_chk(4'd2, 8'h3C, "R9");
    wb_en = 0;
    run_frame(9'h1FF, 2'd0, 8'h00, 9'h1FF, 2'd0, 8'h00, 8'h99);
    rd_chk(4'd0, img_m[0], "R9");
    rd_chk(4'd2, 8'h3C, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 9; a++) img_m[a] = 8'd0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_pass;
    t_register;
    t_serial_timing;
    t_serial;
    t_latch;
    t_g1;
    t_mask;
    t_writeback;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule